// File: doc/BRIEF.md
# Dual-Style Host Bus Slave

This block connects an 8-bit host processor to a bank of 8-bit internal registers addressed by 9 bits. A static mode pin picks the bus style. In separated style the data bus carries only data, the address comes from dedicated pins, one strobe qualifies the cycle and a direction line selects read or write. In multiplexed style the shared bus carries the low address byte and then the data, only the top address bit comes from its own pin, and the two strobe pins become separate read and write strobes.

A second pin picks the cycle timing. In synchronous mode the host clock's rising edge samples the control pins, and a write completes with zero wait states. In asynchronous mode the write strobe captures address and data itself, and the end of the strobe is carried through a two-flop synchronizer into the internal clock domain, where it commits the write once. Synchronous mode takes effect only while the external clock is enabled. Otherwise the host clock is ignored and the internal clock times the block.

Top module: `hbus_if`

## Requirements
- R1: With `mux_mode_i` low, the address is `addr_i[8:0]`, `ds_ni` low qualifies the cycle, and `rw_ni` high means read and low means write.
- R2: With `mux_mode_i` high, the address is `{addr_i[8], ad_i[7:0]}`, and `addr_i[7:0]` has no effect. `ds_ni` low is a read strobe and `rw_ni` low is a write strobe.
- R3: The address is captured on the falling edge of `as_ni`. Later changes on the address pins do not change the selected register until the next falling edge.
- R4: `ad_oe_o` is high only while `cs_ni` is low, a read is indicated and `rst_ni` is high. When `cs_ni` is high, `ad_oe_o` is low.
- R5: When `sync_mode_i` and `ext_clk_en_i` are both high, a write commits at the first rising edge of `hclk_i` at which `as_ni`, `cs_ni` and the write strobe are all low. The data is taken from `ad_i` at that edge.
- R6: When `ext_clk_en_i` is low, `hclk_i` is ignored. The internal clock `clk_i` times the block and the asynchronous mode applies whatever the value of `sync_mode_i`.
- R7: In asynchronous mode, the end of the write strobe (or of `cs_ni`) captures the address and the data. The write commits within 4 internal clocks, even if a new address strobe arrives in the meantime. Two asynchronous writes must be separated by at least 3 clocks with the strobe inactive.
- R8: Each write cycle updates the addressed register exactly once. In synchronous mode, a strobe held over several edges stores only the data present at the first edge.
- R9: When reset is released, register i (i = 0..15) holds its default value, i XOR 0xC3. Reset must be held low for at least 2 clocks.
- R10: Addresses 16 and above are unimplemented. Reads from them return 0x00 and writes to them change no register.
- R11: While `ad_oe_o` is high, `ad_o` carries the value of the register at the captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| hclk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_en_i | input | 1 | Use host clock as the timing clock |
| sync_mode_i | input | 1 | Synchronous cycle sampling |
| mux_mode_i | input | 1 | Multiplexed bus style |
| addr_i | input | 9 | Dedicated address pins |
| ad_i | input | 8 | Bus input: data, or address then data |
| ad_o | output | 8 | Read data driven onto the bus |
| ad_oe_o | output | 1 | Bus output enable |
| as_ni | input | 1 | Address strobe, active low |
| cs_ni | input | 1 | Chip select, active low |
| ds_ni | input | 1 | Data strobe, or read strobe in multiplexed style |
| rw_ni | input | 1 | Direction, or write strobe in multiplexed style |

## Verification
An asynchronous write commit can land in the same internal cycle as the latching of a new address and a read at that new address. The bench provokes this by ending a write and, with no pause, dropping the address strobe for a read of a different register while the synchronizer is still carrying the first write. The read must return the untouched default of the second register. Later reads must show the written value at the first address and an unchanged second register, which proves the commit used its captured address and not the one just latched.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 9;

  // Default value of register idx after reset
  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    return DATA_W'(idx) ^ DATA_W'(8'hC3);
  endfunction
endpackage

// File: rtl/hbus_alat.sv
module hbus_alat #(
  parameter int ADDR_W = hbus_pkg::ADDR_W,
  parameter int DATA_W = hbus_pkg::DATA_W
) (
  input  logic              rst_ni,
  input  logic              as_ni,
  input  logic              mux_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_d;

  // Multiplexed style: high pins from addr_i, low byte from shared bus
  assign addr_d = mux_mode_i ? {addr_i[ADDR_W-1:DATA_W], ad_i} : addr_i;

  always_ff @(negedge as_ni or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else         addr_o <= addr_d;
  end
endmodule

// File: rtl/hbus_cyc.sv
module hbus_cyc #(
  parameter int ADDR_W      = hbus_pkg::ADDR_W,
  parameter int DATA_W      = hbus_pkg::DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              core_rst_ni,
  input  logic              rst_ni,
  input  logic              sync_en_i,
  input  logic              mux_mode_i,
  input  logic              as_ni,
  input  logic              cs_ni,
  input  logic              ds_ni,
  input  logic              rw_ni,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [ADDR_W-1:0] addr_lat_i,
  output logic              rd_act_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic wr_act, wstb;
  logic sync_cond, sync_cond_q, sync_fire, async_fire;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic [SYNC_STAGES:0] wsync_q;

  assign wr_act   = mux_mode_i ? ~rw_ni : (~ds_ni & ~rw_ni);
  assign rd_act_o = mux_mode_i ? ~ds_ni : (~ds_ni &  rw_ni);
  assign wstb     = ~cs_ni & wr_act;

  // Asynchronous path: strobe end captures address and data
  always_ff @(negedge wstb or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      wa_q <= addr_lat_i;
      wd_q <= ad_i;
    end
  end

  // Synchronizer plus one history stage for fall detection
  always_ff @(posedge clk_i or negedge core_rst_ni) begin
    if (!core_rst_ni) wsync_q <= '0;
    else              wsync_q <= {wsync_q[SYNC_STAGES-1:0], wstb};
  end
  assign async_fire = wsync_q[SYNC_STAGES] & ~wsync_q[SYNC_STAGES-1];

  // Synchronous path: first sampled edge of a qualified cycle
  assign sync_cond = ~as_ni & wstb;
  always_ff @(posedge clk_i or negedge core_rst_ni) begin
    if (!core_rst_ni) sync_cond_q <= 1'b0;
    else              sync_cond_q <= sync_cond;
  end
  assign sync_fire = sync_cond & ~sync_cond_q;

  assign wr_en_o   = sync_en_i ? sync_fire  : async_fire;
  assign wr_addr_o = sync_en_i ? addr_lat_i : wa_q;
  assign wr_data_o = sync_en_i ? ad_i       : wd_q;
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
  parameter int ADDR_W   = hbus_pkg::ADDR_W,
  parameter int DATA_W   = hbus_pkg::DATA_W,
  parameter int NUM_REGS = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  rf_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  rf_o[i] <= hbus_pkg::reg_default(i);
      else if (wr_en_i && wr_addr_i == ADDR_W'(i))  rf_o[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/hbus_if.sv
module hbus_if #(
  parameter int NUM_REGS = 16
) (
  input  logic       clk_i,
  input  logic       hclk_i,
  input  logic       rst_ni,
  input  logic       ext_clk_en_i,
  input  logic       sync_mode_i,
  input  logic       mux_mode_i,
  input  logic [8:0] addr_i,
  input  logic [7:0] ad_i,
  output logic [7:0] ad_o,
  output logic       ad_oe_o,
  input  logic       as_ni,
  input  logic       cs_ni,
  input  logic       ds_ni,
  input  logic       rw_ni
);
  import hbus_pkg::*;
  localparam int IDX_W = $clog2(NUM_REGS);

  logic              cyc_clk, sync_en, core_rst_n, rd_act, wr_en;
  logic [1:0]        rst_q;
  logic [ADDR_W-1:0] addr_lat, wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] rf_q;

  // Mode pins are static; timing clock follows the clock mode
  assign cyc_clk = ext_clk_en_i ? hclk_i : clk_i;
  assign sync_en = sync_mode_i & ext_clk_en_i;

  // Async assert, release on second edge
  always_ff @(posedge cyc_clk or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign core_rst_n = rst_q[1];

  hbus_alat #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) alat_i (
    .rst_ni    (rst_ni),
    .as_ni     (as_ni),
    .mux_mode_i(mux_mode_i),
    .addr_i    (addr_i),
    .ad_i      (ad_i),
    .addr_o    (addr_lat)
  );

  hbus_cyc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) cyc_i (
    .clk_i      (cyc_clk),
    .core_rst_ni(core_rst_n),
    .rst_ni     (rst_ni),
    .sync_en_i  (sync_en),
    .mux_mode_i (mux_mode_i),
    .as_ni      (as_ni),
    .cs_ni      (cs_ni),
    .ds_ni      (ds_ni),
    .rw_ni      (rw_ni),
    .ad_i       (ad_i),
    .addr_lat_i (addr_lat),
    .rd_act_o   (rd_act),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  hbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) rf_i (
    .clk_i    (cyc_clk),
    .rst_ni   (core_rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rf_o     (rf_q)
  );

  assign ad_o    = (addr_lat < ADDR_W'(NUM_REGS)) ? rf_q[addr_lat[IDX_W-1:0]] : '0;
  assign ad_oe_o = rst_ni & ~cs_ni & rd_act;
endmodule

// File: rtl/hbus_if_chk.sv
module hbus_if_chk #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                       clk_i,
  input logic                       core_rst_ni,
  input logic                       rst_ni,
  input logic                       cs_ni,
  input logic                       ad_oe_o,
  input logic [7:0]                 ad_o,
  input logic [8:0]                 addr_lat,
  input logic                       wr_en,
  input logic [8:0]                 wr_addr,
  input logic [7:0]                 wr_data,
  input logic [NUM_REGS-1:0][7:0]   rf_q
);
  always_comb begin
    if (rst_ni === 1'b0) AST_OE_IN_RESET: assert (!ad_oe_o); // R4
  end

  AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
    cs_ni |-> !ad_oe_o); // R4

  AST_SINGLE_WRITE: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
    wr_en |=> !wr_en); // R8

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
    (wr_en && wr_addr < 9'(NUM_REGS)) |=> rf_q[$past(wr_addr[IDX_W-1:0])] == $past(wr_data)); // R7

  AST_UNIMP_WR_NOP: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
    (wr_en && wr_addr >= 9'(NUM_REGS)) |=> $stable(rf_q)); // R10

  AST_UNIMP_RD_ZERO: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
    (ad_oe_o && addr_lat >= 9'(NUM_REGS)) |-> ad_o == 8'h00); // R10
endmodule

bind hbus_if hbus_if_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk_i      (cyc_clk),
  .core_rst_ni(core_rst_n),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ad_oe_o    (ad_oe_o),
  .ad_o       (ad_o),
  .addr_lat   (addr_lat),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rf_q       (rf_q)
);

// File: tb/hbus_if_tb_top.sv
`timescale 1ns/1ps
module hbus_if_tb_top;
  logic clk = 0, hclk = 0, hclk_run = 1;
  logic rst_n = 0, ext_en = 0, sync_m = 0, mux_m = 0;
  logic [8:0] addr = '0;
  logic [7:0] ad_in = '0, ad_out;
  logic ad_oe, as_n = 1, cs_n = 1, ds_n = 1, rw_n = 1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  logic       obs_oe;
  event       smp_ev;

  always #2.5 clk = ~clk;
  always #4 if (hclk_run) hclk = ~hclk;

  hbus_if dut_i (
    .clk_i(clk), .hclk_i(hclk), .rst_ni(rst_n), .ext_clk_en_i(ext_en),
    .sync_mode_i(sync_m), .mux_mode_i(mux_m), .addr_i(addr), .ad_i(ad_in),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .as_ni(as_n), .cs_ni(cs_n),
    .ds_ni(ds_n), .rw_ni(rw_n)
  );

  function automatic logic [7:0] dflt(input int i);
    return 8'(i) ^ 8'hC3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  initial forever begin
    @(smp_ev);
    chk(obs_oe === 1'b1 && obs === exp_q[0], tag_q[0], obs, exp_q[0]);
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
  end

  task automatic sample(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    obs = ad_out;
    obs_oe = ad_oe;
    -> smp_ev;
  endtask

  task automatic rd_sep(input logic [8:0] a, input logic [7:0] e, input string tag);
    addr = a; #1 as_n = 0; #1 cs_n = 0; ds_n = 0; #3;
    sample(e, tag);
    #1 ds_n = 1; cs_n = 1; as_n = 1; #3;
  endtask

  task automatic rd_mux(input logic [8:0] a, input logic [7:0] e, input string tag);
    addr = {a[8], 8'hFF}; ad_in = a[7:0]; #1 as_n = 0; #1 ad_in = 8'h3C;
    cs_n = 0; ds_n = 0; #3;
    sample(e, tag);
    #1 ds_n = 1; cs_n = 1; as_n = 1; #3;
  endtask

  task automatic wr_sep_async(input logic [8:0] a, input logic [7:0] d, input bit settle);
    addr = a; ad_in = d; rw_n = 0; #1 as_n = 0; #1 cs_n = 0; ds_n = 0;
    #10 ds_n = 1; #1 cs_n = 1; rw_n = 1; as_n = 1; ad_in = 8'h99;
    if (settle) #30;
  endtask

  task automatic wr_mux_async(input logic [8:0] a, input logic [7:0] d);
    addr = {a[8], 8'hA5}; ad_in = a[7:0]; #1 as_n = 0; #1 ad_in = d;
    cs_n = 0; rw_n = 0; #10 rw_n = 1; #1 cs_n = 1; as_n = 1; ad_in = 8'h99; #30;
  endtask

  task automatic wr_sep_sync(input logic [8:0] a, input logic [7:0] d, input int hold, input logic [7:0] d2);
    @(negedge hclk); addr = a; ad_in = d; as_n = 0; cs_n = 0; rw_n = 0; ds_n = 0;
    @(negedge hclk); ad_in = d2;
    repeat (hold) @(negedge hclk);
    ds_n = 1; rw_n = 1; cs_n = 1; as_n = 1; ad_in = 8'h99;
    @(negedge hclk);
  endtask

  task automatic wr_mux_sync(input logic [8:0] a, input logic [7:0] d);
    @(negedge hclk); addr = {a[8], 8'h5A}; ad_in = a[7:0]; as_n = 0;
    @(negedge hclk); ad_in = d; cs_n = 0; rw_n = 0;
    @(negedge hclk); rw_n = 1; cs_n = 1; as_n = 1; ad_in = 8'h99;
    @(negedge hclk);
  endtask

  initial begin
    // R4: no drive while in reset, even with a read indicated
    #1 cs_n = 0; ds_n = 0; #12;
    chk(ad_oe === 1'b0, "R4 oe in reset", {7'b0, ad_oe}, 8'h00);
    cs_n = 1; ds_n = 1; #3 rst_n = 1; #30;

    // R9 defaults, R10 unimplemented reads
    rd_sep(9'h000, dflt(0),  "R9 reg0");
    rd_sep(9'h005, dflt(5),  "R9 reg5");
    rd_sep(9'h00F, dflt(15), "R9 reg15");
    rd_sep(9'h100, 8'h00, "R10 read 0x100");
    rd_sep(9'h010, 8'h00, "R10 read 0x010");

    // R1 separated async write, R11 readback
    wr_sep_async(9'h003, 8'h5E, 1);
    rd_sep(9'h003, 8'h5E, "R1 R11 reg3");

    // R3: address pins change after strobe
    addr = 9'h003; #1 as_n = 0; #1 addr = 9'h004; cs_n = 0; ds_n = 0; #3;
    sample(8'h5E, "R3 latched addr");
    #1 ds_n = 1; cs_n = 1; as_n = 1; #3;

    // R4: chip select high blocks output
    addr = 9'h003; #1 as_n = 0; ds_n = 0; #3;
    chk(ad_oe === 1'b0, "R4 cs high", {7'b0, ad_oe}, 8'h00);
    ds_n = 1; as_n = 1; #3;

    // R7: new address strobe while commit is pending
    wr_sep_async(9'h006, 8'h91, 0);
    rd_sep(9'h009, dflt(9), "R7 read during commit");
    #30;
    rd_sep(9'h006, 8'h91, "R7 committed addr");
    rd_sep(9'h009, dflt(9), "R7 other reg");

    // R10: write to unimplemented aliasing address
    wr_sep_async(9'h103, 8'hEE, 1);
    rd_sep(9'h003, 8'h5E, "R10 write ignored");

    // R2 multiplexed style
    mux_m = 1; #10;
    wr_mux_async(9'h00A, 8'h4B);
    rd_mux(9'h00A, 8'h4B, "R2 mux reg10");
    rd_mux(9'h10A, 8'h00, "R2 top bit from pin");
    wr_mux_async(9'h10A, 8'h77);
    rd_mux(9'h00A, 8'h4B, "R2 R10 mux unimp write");

    // R6: host clock stopped, sync pin high, ext clock off
    mux_m = 0; sync_m = 1; ext_en = 0; hclk_run = 0; #10;
    wr_sep_async(9'h002, 8'h2D, 1);
    rd_sep(9'h002, 8'h2D, "R6 async without hclk");

    // R5 synchronous mode
    hclk_run = 1; ext_en = 1; #40;
    wr_sep_sync(9'h007, 8'h61, 0, 8'h99);
    rd_sep(9'h007, 8'h61, "R5 sync sep");
    mux_m = 1; #10;
    wr_mux_sync(9'h00C, 8'hB2);
    rd_mux(9'h00C, 8'hB2, "R5 sync mux");

    // R8: long strobe stores first-edge data only
    mux_m = 0; #10;
    wr_sep_sync(9'h008, 8'h19, 3, 8'hE4);
    rd_sep(9'h008, 8'h19, "R8 long strobe");

    // R9: reset mid-run
    ext_en = 0; sync_m = 0; #20;
    rst_n = 0; #15; rst_n = 1; #30;
    rd_sep(9'h003, dflt(3), "R9 reg3 after reset");
    rd_sep(9'h007, dflt(7), "R9 reg7 after reset");

    #20;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule